// File: doc/BRIEF.md
# Interrupt Entry and Vectoring Unit

This unit takes a processor core into an interrupt handler for two causes. The first is an instruction-fetch storage fault, raised by a permission violation, a byte-ordering violation, or both. The second is a level-sensitive external interrupt line. The unit samples its requests every cycle while it is idle. When it accepts a request, it registers the cause and, on the next cycle, drives one cycle of entry results. Those results are write strobes with new values for the two save/restore registers, the machine-state register and the syndrome register, a suppress flag that cancels the faulting instruction, and a redirect address for the handler fetch.

The architectural registers live outside the unit. The unit reads the current machine-state word as an input and returns a cleared copy of it to be written back. The handler address is formed from the high half of the vector prefix register and a per-cause offset field, followed by four zero bits. The storage cause and the external cause each have their own offset field.

The controller has three states. `ST_IDLE` waits and arbitrates. `ST_STORE` drives the storage-fault entry. `ST_EXTERN` drives the external entry. The transitions are: idle to store on a fault flag; idle to extern on external line plus enable with no fault; idle to idle otherwise; store to idle and extern to idle unconditionally after one cycle.

Top module: `intr_entry_unit`

## Requirements
- R1: When `fault_perm` or `fault_bo` is high in an idle cycle, the next cycle drives `suppress` and `esr_we` high together with the other entry strobes.
- R2: On a storage entry `srr0_d` equals the `fault_ea` sampled with the request. On an external entry it equals the sampled `next_pc`.
- R3: On any entry `srr1_d` equals the full `msr_in` word sampled with the request.
- R4: On any entry `msr_d` keeps bits 17, 12 and 9 of the sampled machine state and clears every other bit. These are little-endian indices of big-endian bits 46, 51 and 54. Bit 15 (big-endian 48) is the external enable and is therefore cleared.
- R5: On a storage entry `esr_d` has bit 16 equal to the byte-ordering flag and bit 27 equal to the permission flag, and both may be set at once. All other bits are zero. `esr_we` is never high on an external entry.
- R6: The storage handler address is `{vec_prefix, off_store, 4'b0000}`.
- R7: The external handler address is `{vec_prefix, off_ext, 4'b0000}`.
- R8: An external entry happens only if `ext_irq` and `msr_in[15]` are both high in the same idle cycle. A line that drops before that leaves no record.
- R9: A fault and an external request in the same cycle produce only the storage entry. The external request is accepted later if its line is still high and the enable is set.
- R10: Entry outputs last exactly one cycle. Requests presented during that cycle are ignored. A line held high after its entry, with the written-back machine state (enable cleared), causes no further entry.
- R11: During and right after reset the unit is idle with all strobes, `suppress` and `redirect_valid` low.
- R12: No machine-state bit other than bit 15 affects acceptance of the external request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_perm | input | 1 | Fetch permission violation |
| fault_bo | input | 1 | Fetch byte-ordering violation |
| fault_ea | input | 32 | Effective address of faulting fetch |
| ext_irq | input | 1 | Level-sensitive external interrupt |
| next_pc | input | 32 | Address of next unexecuted instruction |
| msr_in | input | 32 | Current machine-state word |
| vec_prefix | input | 16 | High half of vector prefix register |
| off_store | input | 12 | Offset field for storage cause |
| off_ext | input | 12 | Offset field for external cause |
| suppress | output | 1 | Cancel the faulting instruction |
| srr0_we | output | 1 | Save/restore 0 write strobe |
| srr0_d | output | 32 | Save/restore 0 value |
| srr1_we | output | 1 | Save/restore 1 write strobe |
| srr1_d | output | 32 | Save/restore 1 value |
| msr_we | output | 1 | Machine-state write strobe |
| msr_d | output | 32 | New machine-state value |
| esr_we | output | 1 | Syndrome write strobe |
| esr_d | output | 32 | New syndrome value |
| redirect_valid | output | 1 | Handler fetch redirect |
| redirect_addr | output | 32 | Handler fetch address |

## Verification
A controller stuck in an entry state shows at the ports as `redirect_valid` held past one cycle. A controller that never leaves idle shows as no strobes in the cycle after a request. Either fault appears one cycle after the triggering input. A captured register that is wrong, or that reloads late, appears in the same entry cycle as a mismatch between the save/restore values and the request inputs of the previous cycle. A wrong arbitration choice appears as `suppress` missing, or present, on that same cycle. The sweep covers every combination of fault flags, external line and enable across several machine-state patterns, so each of these faults reaches a compared output within one or two cycles.

// File: rtl/intr_entry_pkg.sv
package intr_entry_pkg;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned BE_BASE = 32;

    function automatic int unsigned le_pos(input int unsigned be);
        return BE_BASE + WORD_W - 1 - be;
    endfunction

    localparam int unsigned MSR_CE  = le_pos(46);
    localparam int unsigned MSR_EE  = le_pos(48);
    localparam int unsigned MSR_ME  = le_pos(51);
    localparam int unsigned MSR_DE  = le_pos(54);
    localparam int unsigned SYN_BO  = le_pos(47);
    localparam int unsigned SYN_PV  = le_pos(36);

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STORE  = 2'd1,
        ST_EXTERN = 2'd2
    } entry_state_e;
endpackage

// File: rtl/intr_cause_arb.sv
module intr_cause_arb (
    input  logic fault_perm,
    input  logic fault_bo,
    input  logic ext_irq,
    input  logic ext_enable,
    output logic take_store,
    output logic take_ext
);
    always_comb begin
        take_store = fault_perm | fault_bo;
        take_ext   = ext_irq & ext_enable & ~take_store;
    end
endmodule

// File: rtl/intr_state_calc.sv
module intr_state_calc
    import intr_entry_pkg::*;
#(
    parameter int unsigned W = WORD_W
) (
    input  logic [W-1:0] old_msr,
    input  logic         perm,
    input  logic         bo,
    output logic [W-1:0] new_msr,
    output logic [W-1:0] new_syn
);
    localparam int unsigned NKEEP = 3;
    localparam int unsigned KEEP_POS [NKEEP] = '{MSR_CE, MSR_ME, MSR_DE};

    logic [W-1:0] keep_mask;

    generate
        for (genvar b = 0; b < W; b++) begin : g_mask
            logic hit;
            always_comb begin
                hit = 1'b0;
                for (int k = 0; k < NKEEP; k++) begin
                    if (KEEP_POS[k] == b) hit = 1'b1;
                end
                keep_mask[b] = hit;
            end
        end
    endgenerate

    always_comb begin
        new_msr         = old_msr & keep_mask;
        new_syn         = '0;
        new_syn[SYN_BO] = bo;
        new_syn[SYN_PV] = perm;
    end
endmodule

// File: rtl/intr_vector_gen.sv
module intr_vector_gen #(
    parameter int unsigned W        = 32,
    parameter int unsigned PREFIX_W = 16,
    parameter int unsigned OFF_W    = 12
) (
    input  logic [PREFIX_W-1:0] prefix,
    input  logic [OFF_W-1:0]    offset,
    output logic [W-1:0]        vec_addr
);
    localparam int unsigned ZERO_W = W - PREFIX_W - OFF_W;

    always_comb begin
        vec_addr = {prefix, offset, {ZERO_W{1'b0}}};
    end
endmodule

// File: rtl/intr_entry_unit.sv
module intr_entry_unit
    import intr_entry_pkg::*;
#(
    parameter int unsigned W        = WORD_W,
    parameter int unsigned PREFIX_W = 16,
    parameter int unsigned OFF_W    = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fault_perm,
    input  logic                fault_bo,
    input  logic [W-1:0]        fault_ea,
    input  logic                ext_irq,
    input  logic [W-1:0]        next_pc,
    input  logic [W-1:0]        msr_in,
    input  logic [PREFIX_W-1:0] vec_prefix,
    input  logic [OFF_W-1:0]    off_store,
    input  logic [OFF_W-1:0]    off_ext,
    output logic                suppress,
    output logic                srr0_we,
    output logic [W-1:0]        srr0_d,
    output logic                srr1_we,
    output logic [W-1:0]        srr1_d,
    output logic                msr_we,
    output logic [W-1:0]        msr_d,
    output logic                esr_we,
    output logic [W-1:0]        esr_d,
    output logic                redirect_valid,
    output logic [W-1:0]        redirect_addr
);
    entry_state_e state_q, state_d;

    logic          take_store, take_ext;
    logic [W-1:0]  ret_addr_q;
    logic [W-1:0]  saved_msr_q;
    logic          perm_q, bo_q;
    logic [W-1:0]  calc_msr, calc_syn, calc_vec;
    logic [OFF_W-1:0] sel_off;

    intr_cause_arb u_arb (
        .fault_perm (fault_perm),
        .fault_bo   (fault_bo),
        .ext_irq    (ext_irq),
        .ext_enable (msr_in[MSR_EE]),
        .take_store (take_store),
        .take_ext   (take_ext)
    );

    intr_state_calc #(.W(W)) u_calc (
        .old_msr (saved_msr_q),
        .perm    (perm_q),
        .bo      (bo_q),
        .new_msr (calc_msr),
        .new_syn (calc_syn)
    );

    assign sel_off = (state_q == ST_STORE) ? off_store : off_ext;

    intr_vector_gen #(.W(W), .PREFIX_W(PREFIX_W), .OFF_W(OFF_W)) u_vec (
        .prefix   (vec_prefix),
        .offset   (sel_off),
        .vec_addr (calc_vec)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // capture of entry context, loaded only on acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ret_addr_q  <= '0;
            saved_msr_q <= '0;
            perm_q      <= 1'b0;
            bo_q        <= 1'b0;
        end else if (state_q == ST_IDLE && (take_store || take_ext)) begin
            ret_addr_q  <= take_store ? fault_ea : next_pc;
            saved_msr_q <= msr_in;
            perm_q      <= fault_perm & take_store;
            bo_q        <= fault_bo & take_store;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take_store)    state_d = ST_STORE;
                else if (take_ext) state_d = ST_EXTERN;
                else               state_d = ST_IDLE;
            end
            ST_STORE:  state_d = ST_IDLE;
            ST_EXTERN: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        suppress       = 1'b0;
        srr0_we        = 1'b0;
        srr1_we        = 1'b0;
        msr_we         = 1'b0;
        esr_we         = 1'b0;
        redirect_valid = 1'b0;
        srr0_d         = '0;
        srr1_d         = '0;
        msr_d          = '0;
        esr_d          = '0;
        redirect_addr  = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_STORE: begin
                suppress       = 1'b1;
                srr0_we        = 1'b1;
                srr1_we        = 1'b1;
                msr_we         = 1'b1;
                esr_we         = 1'b1;
                redirect_valid = 1'b1;
                srr0_d         = ret_addr_q;
                srr1_d         = saved_msr_q;
                msr_d          = calc_msr;
                esr_d          = calc_syn;
                redirect_addr  = calc_vec;
            end
            ST_EXTERN: begin
                srr0_we        = 1'b1;
                srr1_we        = 1'b1;
                msr_we         = 1'b1;
                redirect_valid = 1'b1;
                srr0_d         = ret_addr_q;
                srr1_d         = saved_msr_q;
                msr_d          = calc_msr;
                redirect_addr  = calc_vec;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/intr_entry_chk.sv
module intr_entry_chk
    import intr_entry_pkg::*;
#(
    parameter int unsigned W = WORD_W
) (
    input logic         clk,
    input logic         rst_n,
    input logic         fault_perm,
    input logic         fault_bo,
    input logic [W-1:0] fault_ea,
    input logic         ext_irq,
    input logic [W-1:0] msr_in,
    input logic         suppress,
    input logic         esr_we,
    input logic         msr_we,
    input logic [W-1:0] msr_d,
    input logic [W-1:0] srr0_d,
    input logic [W-1:0] srr1_d,
    input logic         redirect_valid
);
    localparam logic [W-1:0] KEEP = (W'(1) << MSR_CE) | (W'(1) << MSR_ME) | (W'(1) << MSR_DE);

    a_r1_fault_enters: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect_valid && (fault_perm || fault_bo)) |=> (suppress && esr_we));

    a_r2_srr0_from_ea: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_valid && suppress) |-> (srr0_d == $past(fault_ea)));

    a_r3_srr1_prev_msr: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> (srr1_d == $past(msr_in)));

    a_r4_msr_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        msr_we |-> (msr_d == (srr1_d & KEEP)));

    a_r8_ee_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_valid && !suppress) |-> ($past(ext_irq) && $past(msr_in[MSR_EE])));

    a_r9_store_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect_valid && (fault_perm || fault_bo) && ext_irq) |=> suppress);

    a_r10_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> !redirect_valid);
endmodule

bind intr_entry_unit intr_entry_chk #(.W(W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .fault_perm     (fault_perm),
    .fault_bo       (fault_bo),
    .fault_ea       (fault_ea),
    .ext_irq        (ext_irq),
    .msr_in         (msr_in),
    .suppress       (suppress),
    .esr_we         (esr_we),
    .msr_we         (msr_we),
    .msr_d          (msr_d),
    .srr0_d         (srr0_d),
    .srr1_d         (srr1_d),
    .redirect_valid (redirect_valid)
);

// File: tb/tb_intr_entry_unit.sv
module tb_intr_entry_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fault_perm = 1'b0, fault_bo = 1'b0, ext_irq = 1'b0;
    logic [31:0] fault_ea = '0, next_pc = '0, msr_in = '0;
    logic [15:0] vec_prefix = 16'hABCD;
    logic [11:0] off_store = 12'hF38, off_ext = 12'h504;
    logic        suppress, srr0_we, srr1_we, msr_we, esr_we, redirect_valid;
    logic [31:0] srr0_d, srr1_d, msr_d, esr_d, redirect_addr;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [31:0] KEEP = (32'd1 << 17) | (32'd1 << 12) | (32'd1 << 9);
    localparam logic [31:0] EE   = 32'd1 << 15;

    always #4 clk = ~clk;

    intr_entry_unit dut (
        .clk(clk), .rst_n(rst_n),
        .fault_perm(fault_perm), .fault_bo(fault_bo), .fault_ea(fault_ea),
        .ext_irq(ext_irq), .next_pc(next_pc), .msr_in(msr_in),
        .vec_prefix(vec_prefix), .off_store(off_store), .off_ext(off_ext),
        .suppress(suppress), .srr0_we(srr0_we), .srr0_d(srr0_d),
        .srr1_we(srr1_we), .srr1_d(srr1_d), .msr_we(msr_we), .msr_d(msr_d),
        .esr_we(esr_we), .esr_d(esr_d),
        .redirect_valid(redirect_valid), .redirect_addr(redirect_addr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_idle(input string req);
        chk({req, " suppress"}, 32'(suppress), 0);
        chk({req, " strobes"}, {27'd0, srr0_we, srr1_we, msr_we, esr_we, redirect_valid}, 0);
    endtask

    task automatic chk_entry(input logic ts, input logic te, input logic [31:0] ea,
                             input logic [31:0] npc, input logic [31:0] m,
                             input logic p, input logic b);
        logic any;
        any = ts | te;
        chk("R1 suppress", 32'(suppress), 32'(ts));
        chk("R5 esr_we", 32'(esr_we), 32'(ts));
        chk("R10 entry strobes", {28'd0, srr0_we, srr1_we, msr_we, redirect_valid},
            any ? 32'hF : 32'h0);
        if (any) begin
            chk("R2 srr0_d", srr0_d, ts ? ea : npc);
            chk("R3 srr1_d", srr1_d, m);
            chk("R4 msr_d", msr_d, m & KEEP);
            if (ts) begin
                chk("R5 esr_d", esr_d, (32'(b) << 16) | (32'(p) << 27));
                chk("R6 store vector", redirect_addr, (32'(vec_prefix) << 16) | (32'(off_store) << 4));
            end else begin
                chk("R7 ext vector", redirect_addr, (32'(vec_prefix) << 16) | (32'(off_ext) << 4));
            end
        end
    endtask

    task automatic clear_in();
        fault_perm = 0; fault_bo = 0; ext_irq = 0;
    endtask

    initial begin
        #(8 * 100000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] bases [4];
        bases[0] = 32'h0000_0000;
        bases[1] = 32'hFFFF_FFFF;
        bases[2] = 32'hA5A5_5A5A;
        bases[3] = KEEP;

        repeat (3) @(negedge clk);
        chk_idle("R11 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R11 after reset");

        // R12 sweep: flags x line x enable x machine-state patterns
        for (int bi = 0; bi < 4; bi++) begin
            for (int c = 0; c < 16; c++) begin
                logic p, b, x, e, ts, te;
                logic [31:0] m;
                p = c[0]; b = c[1]; x = c[2]; e = c[3];
                m = e ? (bases[bi] | EE) : (bases[bi] & ~EE);
                ts = p | b;
                te = !ts && x && e;
                fault_perm = p; fault_bo = b; ext_irq = x; msr_in = m;
                fault_ea = 32'h4000_0000 + 32'(bi * 64 + c * 4);
                next_pc  = 32'h8000_0100 + 32'(bi * 64 + c * 4);
                @(negedge clk);
                chk_entry(ts, te, fault_ea, next_pc, m, p, b);
                @(negedge clk);
                chk_idle("R10 inputs held in entry cycle");
                clear_in();
                @(negedge clk);
            end
        end

        // R8: line drops before the enable rises
        msr_in = 32'h0; ext_irq = 1;
        @(negedge clk);
        chk_idle("R8 masked line");
        ext_irq = 0; msr_in = EE;
        @(negedge clk);
        chk_idle("R8 no memory of dropped line");
        @(negedge clk);
        chk_idle("R8 no memory of dropped line");

        // R10: held line after entry with written-back machine state
        msr_in = 32'h0003_F000 | EE; ext_irq = 1; next_pc = 32'h0000_2224;
        @(negedge clk);
        chk_entry(0, 1, 32'h0, next_pc, msr_in, 0, 0);
        msr_in = msr_d;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk_idle("R10 held line no re-entry");
        end
        msr_in = msr_in | EE;
        @(negedge clk);
        chk_entry(0, 1, 32'h0, next_pc, msr_in, 0, 0);
        clear_in();
        @(negedge clk);

        // R9: both together, storage first, external later while held
        msr_in = EE | 32'h0000_0003; ext_irq = 1; fault_bo = 1; fault_perm = 1;
        fault_ea = 32'h0BAD_0F00; next_pc = 32'h0000_3330;
        @(negedge clk);
        chk_entry(1, 0, fault_ea, next_pc, msr_in, 1, 1);
        fault_bo = 0; fault_perm = 0;
        @(negedge clk);
        chk_idle("R9 entry cycle gap");
        @(negedge clk);
        chk_entry(0, 1, fault_ea, next_pc, msr_in, 0, 0);
        clear_in();
        @(negedge clk);
        chk_idle("R11 quiet end");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule